// File: doc/BRIEF.md
# External Bus Area Decoder

This block sits between a CPU's external bus request and the memories behind it. For each request it works out which of five external memory areas the address falls in. It drives that area's active-low chip select for a programmed number of cycles and returns a one-cycle ready pulse in the last of those cycles. An address that hits no area produces a one-cycle error pulse and asserts no chip select.

Each area has three settings that software writes through a simple write port: the data bus width (8, 16 or 32 bits), the count of wait cycles added to each access, and the count of idle cycles that must pass after an access before the next request is taken. The bus width of the area in use is presented on a two-bit output for the external data path. A mode input chooses between two address maps. In the narrow map the two upper areas cover only half of their 64 MB slot. In the wide map every area covers its full slot.

Top module: `ext_area_decoder`

## Requirements
- R1: After a synchronous reset every chip select is high (deasserted), `ready` and `err` are low, and every area holds width code 1 (16 bits), wait 0 and idle 0.
- R2: Address bits [28:26] select a 64 MB slot. Slot 0 drives `cs_n[0]`, slot 3 drives `cs_n[1]`, slot 4 drives `cs_n[2]`, slot 5 drives `cs_n[3]` and slot 6 drives `cs_n[4]`. Area index i in the configuration port refers to `cs_n[i]`.
- R3: With `map_mode` = 0 (narrow map), slots 5 and 6 hit only when address bit 25 is 0. If bit 25 is 1 the request is an error. With `map_mode` = 1 (wide map), bit 25 is ignored.
- R4: A request to slot 1, 2 or 7, or a narrow-map miss, raises `err` for exactly one cycle, the cycle after the request is accepted, and no chip select goes low.
- R5: At no time is more than one chip select low.
- R6: An accepted access holds its chip select low for exactly 1 + wait consecutive cycles. The first of these is the cycle after the accepting clock edge. `ready` is high only in the last of them, and the chip select is high in the cycle after `ready`.
- R7: While a chip select is low, `bus_size` shows that area's width code: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits.
- R8: A configuration write of width code 2 to area 0 is dropped, and so is a write of width code 3 to any area. Such a write changes none of that area's fields.
- R9: Between the end of one access and the chip select of the next, the chip selects stay high for idle + 1 cycles, where idle belongs to the area just accessed. This holds even when the next request targets a different area.
- R10: `ready` and `err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_mode | input | 1 | 0 = narrow map, 1 = wide map |
| req | input | 1 | Access request, held until `ready` or `err` |
| addr | input | 29 | Byte address of the request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_area | input | 3 | Area index 0..4 to write |
| cfg_width | input | 2 | Width code to write |
| cfg_wait | input | 4 | Wait cycle count to write |
| cfg_idle | input | 3 | Idle cycle count to write |
| cs_n | output | 5 | Active-low chip selects, one per area |
| bus_size | output | 2 | Width code of the area being accessed |
| ready | output | 1 | One-cycle pulse in the last cycle of an access |
| err | output | 1 | One-cycle pulse for a request that hits no area |

## Verification
The bench probes address bit 25 in both map modes on slots 5 and 6. A decoder that ignored the mode would answer with a chip select where an error is due. The bench also counts the high cycles between back-to-back accesses when the second access goes to a different area. A sequencer that took the idle count from the new area, or that let an area switch skip the gap, would show the wrong count there. It tries a 32-bit write to area 0 and a reserved width code, then reads the width back through `bus_size`. A register that accepted either write would expose a width the external bus cannot use. Zero and maximum wait counts confirm that `ready` lands in the last chip-select cycle without an off-by-one.

// File: rtl/eab_pkg.sv
package eab_pkg;
  localparam int NUM_AREAS  = 5;
  localparam int AREA_IDX_W = 3;

  typedef enum logic [1:0] {
    BW8   = 2'd0,
    BW16  = 2'd1,
    BW32  = 2'd2,
    BWRSV = 2'd3
  } bw_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_GAP    = 2'd2
  } seq_st_e;
endpackage

// File: rtl/eab_area_decode.sv
module eab_area_decode
  import eab_pkg::*;
(
  input  logic [3:0]            addr_top,   // {slot[2:0], half bit}
  input  logic                  map_mode,
  output logic                  hit,
  output logic [AREA_IDX_W-1:0] area_idx
);
  logic [2:0] slot;
  logic       upper_half;

  assign slot       = addr_top[3:1];
  assign upper_half = addr_top[0];

  always_comb begin
    hit      = 1'b0;
    area_idx = '0;
    unique case (slot)
      3'd0: begin hit = 1'b1; area_idx = AREA_IDX_W'(0); end
      3'd3: begin hit = 1'b1; area_idx = AREA_IDX_W'(1); end
      3'd4: begin hit = 1'b1; area_idx = AREA_IDX_W'(2); end
      3'd5: begin hit = map_mode | ~upper_half; area_idx = AREA_IDX_W'(3); end
      3'd6: begin hit = map_mode | ~upper_half; area_idx = AREA_IDX_W'(4); end
      default: begin hit = 1'b0; area_idx = '0; end
    endcase
  end
endmodule

// File: rtl/eab_cfg_bank.sv
module eab_cfg_bank
  import eab_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int IDLE_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [AREA_IDX_W-1:0] cfg_area,
  input  logic [1:0]            cfg_width,
  input  logic [WAIT_W-1:0]     cfg_wait,
  input  logic [IDLE_W-1:0]     cfg_idle,
  input  logic [AREA_IDX_W-1:0] sel_idx,
  output bw_e                   sel_width,
  output logic [WAIT_W-1:0]     sel_wait,
  output logic [IDLE_W-1:0]     sel_idle
);
  bw_e               width_r [NUM_AREAS];
  logic [WAIT_W-1:0] wait_r  [NUM_AREAS];
  logic [IDLE_W-1:0] idle_r  [NUM_AREAS];

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
    logic legal;
    // area 0 has no 32-bit option; the reserved code is refused everywhere
    assign legal = (bw_e'(cfg_width) != BWRSV) &&
                   !((g == 0) && (bw_e'(cfg_width) == BW32));

    always_ff @(posedge clk) begin
      if (rst) begin
        width_r[g] <= BW16;
        wait_r[g]  <= '0;
        idle_r[g]  <= '0;
      end else if (cfg_we && (cfg_area == AREA_IDX_W'(g)) && legal) begin
        width_r[g] <= bw_e'(cfg_width);
        wait_r[g]  <= cfg_wait;
        idle_r[g]  <= cfg_idle;
      end
    end
  end

  always_comb begin
    sel_width = BW8;
    sel_wait  = '0;
    sel_idle  = '0;
    for (int i = 0; i < NUM_AREAS; i++) begin
      if (sel_idx == AREA_IDX_W'(i)) begin
        sel_width = width_r[i];
        sel_wait  = wait_r[i];
        sel_idle  = idle_r[i];
      end
    end
  end
endmodule

// File: rtl/eab_seq.sv
module eab_seq
  import eab_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int IDLE_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  logic                  hit,
  input  logic [AREA_IDX_W-1:0] area_idx,
  input  bw_e                   area_width,
  input  logic [WAIT_W-1:0]     area_wait,
  input  logic [IDLE_W-1:0]     area_idle,
  output logic [NUM_AREAS-1:0]  cs_n,
  output logic [1:0]            bus_size,
  output logic                  ready,
  output logic                  err
);
  localparam int CNT_W = (WAIT_W > IDLE_W) ? WAIT_W : IDLE_W;

  seq_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [IDLE_W-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cs_n     <= '1;
      bus_size <= BW8;
      ready    <= 1'b0;
      err      <= 1'b0;
      cnt      <= '0;
      idle_q   <= '0;
    end else begin
      ready <= 1'b0;
      err   <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          // a request answered by err must drop before it is taken again
          if (req && !err) begin
            if (hit) begin
              cs_n     <= ~(NUM_AREAS'(1) << area_idx);
              bus_size <= area_width;
              cnt      <= CNT_W'(area_wait);
              idle_q   <= area_idle;
              ready    <= (area_wait == '0);
              st       <= ST_ACCESS;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_ACCESS: begin
          if (cnt == '0) begin
            cs_n <= '1;
            if (idle_q == '0) begin
              st <= ST_IDLE;
            end else begin
              cnt <= CNT_W'(idle_q - 1'b1);
              st  <= ST_GAP;
            end
          end else begin
            cnt   <= cnt - 1'b1;
            ready <= (cnt == CNT_W'(1));
          end
        end
        ST_GAP: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ext_area_decoder.sv
module ext_area_decoder
  import eab_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int WAIT_W = 4,
  parameter int IDLE_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  map_mode,
  input  logic                  req,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  cfg_we,
  input  logic [AREA_IDX_W-1:0] cfg_area,
  input  logic [1:0]            cfg_width,
  input  logic [WAIT_W-1:0]     cfg_wait,
  input  logic [IDLE_W-1:0]     cfg_idle,
  output logic [NUM_AREAS-1:0]  cs_n,
  output logic [1:0]            bus_size,
  output logic                  ready,
  output logic                  err
);
  localparam int TOP_LSB = ADDR_W - 4;

  logic                  hit;
  logic [AREA_IDX_W-1:0] area_idx;
  bw_e                   sel_width;
  logic [WAIT_W-1:0]     sel_wait;
  logic [IDLE_W-1:0]     sel_idle;
  logic                  unused_low_addr;

  assign unused_low_addr = ^addr[TOP_LSB-1:0];

  eab_area_decode u_decode (
    .addr_top (addr[ADDR_W-1:TOP_LSB]),
    .map_mode (map_mode),
    .hit      (hit),
    .area_idx (area_idx)
  );

  eab_cfg_bank #(.WAIT_W(WAIT_W), .IDLE_W(IDLE_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_area  (cfg_area),
    .cfg_width (cfg_width),
    .cfg_wait  (cfg_wait),
    .cfg_idle  (cfg_idle),
    .sel_idx   (area_idx),
    .sel_width (sel_width),
    .sel_wait  (sel_wait),
    .sel_idle  (sel_idle)
  );

  eab_seq #(.WAIT_W(WAIT_W), .IDLE_W(IDLE_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .hit        (hit),
    .area_idx   (area_idx),
    .area_width (sel_width),
    .area_wait  (sel_wait),
    .area_idle  (sel_idle),
    .cs_n       (cs_n),
    .bus_size   (bus_size),
    .ready      (ready),
    .err        (err)
  );
endmodule

// File: rtl/eab_checker.sv
module eab_checker
  import eab_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_AREAS-1:0] cs_n,
  input logic [1:0]           bus_size,
  input logic                 ready,
  input logic                 err
);
  localparam int RUN_W = WAIT_W + 2;
  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)                low_run <= '0;
    else if (cs_n != '1)    low_run <= low_run + 1'b1;
    else                    low_run <= '0;
  end

  assert_one_cs_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(ready && err));

  assert_err_no_cs_R4: assert property (@(posedge clk) disable iff (rst)
    err |-> (cs_n == '1));

  assert_ready_in_window_R6: assert property (@(posedge clk) disable iff (rst)
    ready |-> (cs_n != '1));

  assert_release_after_ready_R6: assert property (@(posedge clk) disable iff (rst)
    ready |=> (cs_n == '1));

  assert_hold_cs_R6: assert property (@(posedge clk) disable iff (rst)
    ((cs_n != '1) && !ready) |=> ($stable(cs_n) && $stable(bus_size)));

  assert_window_bound_R6: assert property (@(posedge clk) disable iff (rst)
    low_run <= RUN_W'(1 << WAIT_W));

  assert_area0_width_R8: assert property (@(posedge clk) disable iff (rst)
    !cs_n[0] |-> (bus_size != 2'd2));

  assert_width_code_R7: assert property (@(posedge clk) disable iff (rst)
    (cs_n != '1) |-> (bus_size != 2'd3));
endmodule

bind ext_area_decoder eab_checker #(.WAIT_W(WAIT_W)) u_eab_checker (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .bus_size (bus_size),
  .ready    (ready),
  .err      (err)
);

// File: tb/tb_ext_area_decoder.sv
`timescale 1ns/1ps
module tb_ext_area_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        map_mode;
  logic        req;
  logic [28:0] addr;
  logic        cfg_we;
  logic [2:0]  cfg_area;
  logic [1:0]  cfg_width;
  logic [3:0]  cfg_wait;
  logic [2:0]  cfg_idle;
  logic [4:0]  cs_n;
  logic [1:0]  bus_size;
  logic        ready;
  logic        err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  ext_area_decoder dut (
    .clk(clk), .rst(rst), .map_mode(map_mode), .req(req), .addr(addr),
    .cfg_we(cfg_we), .cfg_area(cfg_area), .cfg_width(cfg_width),
    .cfg_wait(cfg_wait), .cfg_idle(cfg_idle),
    .cs_n(cs_n), .bus_size(bus_size), .ready(ready), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [28:0] mk_addr(input int slot, input bit b25);
    return {slot[2:0], b25, 25'h0_1234};
  endfunction

  task automatic cfg(input int area, input int w, input int wt, input int idl);
    @(negedge clk);
    cfg_we = 1; cfg_area = area[2:0]; cfg_width = w[1:0];
    cfg_wait = wt[3:0]; cfg_idle = idl[2:0];
    @(negedge clk);
    cfg_we = 0;
  endtask

  // exp_area < 0 means an error response is expected
  task automatic do_access(input logic [28:0] a, input bit mm, input int exp_area,
                           input int exp_wait, input int exp_size, input string tag);
    int lowcnt = 0, n = 0, rdy_at = -1;
    bit got_r = 0, got_e = 0;
    logic [4:0] cs_seen = 5'h1f;
    logic [1:0] sz_seen = 2'd0;
    @(negedge clk);
    map_mode = mm; addr = a; req = 1;
    while (!got_r && !got_e && n < 64) begin
      @(negedge clk);
      n++;
      if (cs_n != 5'h1f) begin lowcnt++; cs_seen = cs_n; sz_seen = bus_size; end
      if (ready) begin got_r = 1; rdy_at = lowcnt; end
      if (err) got_e = 1;
    end
    req = 0;
    if (exp_area < 0) begin
      chk(got_e && n == 1, {tag, " err pulse"}, int'(got_e), 1);
      chk(lowcnt == 0, {tag, " no cs on miss"}, lowcnt, 0);
      @(negedge clk);
      chk(!err, {tag, " err one cycle"}, int'(err), 0);
    end else begin
      chk(got_r, {tag, " ready seen"}, int'(got_r), 1);
      chk(cs_seen == ~(5'd1 << exp_area), {tag, " cs line"}, int'(cs_seen),
          int'(~(5'd1 << exp_area) & 5'h1f));
      chk(lowcnt == exp_wait + 1 && rdy_at == exp_wait + 1, {tag, " window"},
          lowcnt, exp_wait + 1);
      chk(int'(sz_seen) == exp_size, {tag, " bus_size"}, int'(sz_seen), exp_size);
      @(negedge clk);
      chk(cs_n == 5'h1f && !ready, {tag, " release"}, int'(cs_n), 31);
    end
    repeat (10) @(negedge clk);
  endtask

  // hold req through A and on to B; count high cycles between them
  task automatic gap_check(input logic [28:0] a, input logic [28:0] b,
                           input int exp_gap, input string tag);
    int n = 0, gap = 0;
    @(negedge clk);
    map_mode = 1; addr = a; req = 1;
    while (!ready && n < 64) begin @(negedge clk); n++; end
    addr = b;
    @(negedge clk);
    while (cs_n == 5'h1f && gap < 64) begin gap++; @(negedge clk); end
    chk(gap == exp_gap, {tag, " idle gap"}, gap, exp_gap);
    n = 0;
    while (!ready && n < 64) begin @(negedge clk); n++; end
    req = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(cs_n == 5'h1f, "R1 cs_n after reset", int'(cs_n), 31);
    chk(!ready && !err, "R1 ready/err after reset", int'({ready, err}), 0);
    do_access(mk_addr(0, 0), 1, 0, 0, 1, "R1 default area0");
  endtask

  task automatic t_each_area;
    cfg(0, 0, 2, 0);
    cfg(1, 2, 0, 0);
    cfg(2, 1, 5, 0);
    cfg(3, 2, 15, 0);
    cfg(4, 0, 1, 0);
    do_access(mk_addr(0, 0), 1, 0, 2, 0, "R2 R6 R7 slot0");
    do_access(mk_addr(3, 1), 1, 1, 0, 2, "R2 R6 R7 slot3 wait0");
    do_access(mk_addr(4, 0), 1, 2, 5, 1, "R2 R6 R7 slot4");
    do_access(mk_addr(5, 1), 1, 3, 15, 2, "R2 R6 R7 slot5 wait max");
    do_access(mk_addr(6, 0), 1, 4, 1, 0, "R2 R6 R7 slot6");
  endtask

  task automatic t_map_modes;
    do_access(mk_addr(5, 1), 0, -1, 0, 0, "R3 narrow slot5 upper");
    do_access(mk_addr(6, 1), 0, -1, 0, 0, "R3 narrow slot6 upper");
    do_access(mk_addr(5, 0), 0, 3, 15, 2, "R3 narrow slot5 lower");
    do_access(mk_addr(6, 1), 1, 4, 1, 0, "R3 wide slot6 upper");
    do_access(mk_addr(0, 1), 0, 0, 2, 0, "R3 narrow slot0 upper");
  endtask

  task automatic t_unmapped;
    do_access(mk_addr(1, 0), 1, -1, 0, 0, "R4 slot1");
    do_access(mk_addr(2, 1), 1, -1, 0, 0, "R4 slot2");
    do_access(mk_addr(7, 0), 0, -1, 0, 0, "R4 slot7");
  endtask

  task automatic t_width_rules;
    cfg(0, 2, 7, 3);   // refused: area0 may not be 32-bit
    do_access(mk_addr(0, 0), 1, 0, 2, 0, "R8 area0 32-bit write dropped");
    cfg(2, 3, 9, 2);   // refused: reserved code
    do_access(mk_addr(4, 0), 1, 2, 5, 1, "R8 reserved code dropped");
    cfg(0, 1, 3, 0);
    do_access(mk_addr(0, 0), 1, 0, 3, 1, "R8 area0 16-bit accepted");
  endtask

  task automatic t_idle;
    cfg(1, 2, 1, 3);
    cfg(2, 1, 0, 0);
    gap_check(mk_addr(3, 0), mk_addr(3, 0), 4, "R9 same area");
    gap_check(mk_addr(3, 0), mk_addr(4, 0), 4, "R9 to other area");
    gap_check(mk_addr(4, 0), mk_addr(3, 0), 1, "R9 from idle0 area");
    cfg(4, 0, 0, 7);
    gap_check(mk_addr(6, 0), mk_addr(0, 0), 8, "R9 idle max");
  endtask

  task automatic t_excl;
    // R10: ready and err on a back-to-back hit then miss
    do_access(mk_addr(4, 0), 1, 2, 0, 1, "R10 hit before miss");
    do_access(mk_addr(2, 0), 1, -1, 0, 0, "R10 miss after hit");
    chk(!(ready && err), "R10 exclusive", int'({ready, err}), 0);
  endtask

  initial begin
    rst = 1; map_mode = 1; req = 0; addr = '0;
    cfg_we = 0; cfg_area = 0; cfg_width = 0; cfg_wait = 0; cfg_idle = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_each_area();
    t_map_modes();
    t_unmapped();
    t_width_rules();
    t_idle();
    t_excl();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule